// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block sits beside the instruction fetch unit. Every cycle it takes the current fetch address, searches a small fully associative table of recently taken branches, and in the same cycle returns the address to fetch next. On a hit it also returns the instruction word stored at that target. Fetch can then issue the target instruction straight away and fold the jump out of the pipeline. On a miss it points fetch at the next sequential instruction. No decode of the fetched word is needed for any of this.

The execute stage trains the table through a single resolve port. It reports the branch address, whether the branch was taken, the real target and the instruction found at that target. Only taken branches get an entry. A branch that turns out not taken loses its entry. A taken branch whose target has moved gets its entry rewritten in place. New entries replace slots in strict round-robin order. A resolve for the same address that fetch is looking up in that cycle overrides the stored contents, so fetch never acts on a stale entry.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid and the allocation pointer is at slot 0. Until a taken resolve arrives, every lookup misses.
- R2: On a miss, `pred_hit` is 0, `pred_next_pc` is `fetch_pc + INSTR_BYTES` (4 by default) and `pred_instr` is 0.
- R3: A taken resolve for an address not in the table allocates an entry. From the next cycle, a lookup of that address hits and returns the resolved target and instruction.
- R4: A not-taken resolve for an address not in the table changes no entry. Lookups of that address keep missing.
- R5: A not-taken resolve for an address in the table invalidates its entry. From the next cycle, lookups of that address miss.
- R6: A taken resolve for an address already in the table rewrites that entry's target and instruction in place. The allocation pointer does not move.
- R7: A new allocation goes to the slot under the round-robin pointer. The pointer then advances by one and wraps from ENTRIES-1 to 0. With 16 entries, the 17th allocation evicts the 1st.
- R8: When `upd_valid` is high and `upd_pc` equals `fetch_pc`, the resolve decides the result of that cycle. If the branch was taken, the lookup hits with `upd_target` and `upd_instr`. If it was not taken, the lookup gives the miss outputs of R2.
- R9: At most one valid entry ever matches a given address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| pred_hit | output | 1 | Lookup found a taken-branch entry |
| pred_next_pc | output | ADDR_W | Predicted next fetch address |
| pred_instr | output | INSTR_W | Instruction at the predicted target, 0 on a miss |
| upd_valid | input | 1 | A branch resolves this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved branch was taken |
| upd_target | input | ADDR_W | Actual target of the resolved branch |
| upd_instr | input | INSTR_W | Instruction word at the actual target |

## Verification
The bench fills the table past capacity and checks that the oldest allocation, and only that one, is evicted. A pointer that skips, sticks or advances on an in-place rewrite would evict the wrong branch or none at all. It retargets a live entry and then resolves it not taken. A design that allocated a second copy of the entry would keep hitting with the old target. It also drives resolves against the address being fetched in the same cycle, both taken and not taken. A design without that override would return stale contents for one cycle. A long random stream over a small address set mixes all of these against a behavioural model on every cycle.

// File: rtl/btb_pkg.sv
// Shared definitions for the branch target predictor.
// Assumes nothing beyond IEEE 1800-2017 packages.
package btb_pkg;

    // Action taken on the table by one resolve from execute.
    typedef enum logic [1:0] {
        UPD_NONE    = 2'd0,
        UPD_ALLOC   = 2'd1,
        UPD_REWRITE = 2'd2,
        UPD_DROP    = 2'd3
    } upd_kind_e;

    // Classify a resolve by its valid flag, direction and table presence.
    function automatic upd_kind_e classify(input logic valid,
                                           input logic taken,
                                           input logic present);
        if (!valid)               return UPD_NONE;
        else if (taken && present) return UPD_REWRITE;
        else if (taken)            return UPD_ALLOC;
        else if (present)          return UPD_DROP;
        else                       return UPD_NONE;
    endfunction

endpackage

// File: rtl/btb_match.sv
// Associative tag search: compares one key against every valid entry.
// Produces a one-hot match vector, a hit flag and the binary index.
// Assumes at most one entry matches (kept true by the update logic).
module btb_match #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ADDR_W-1:0]  key,
    input  logic [ENTRIES-1:0] valid,
    input  logic [ADDR_W-1:0]  tags [ENTRIES],
    output logic [ENTRIES-1:0] onehot,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);

    // Per-entry comparators.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign onehot[i] = valid[i] && (tags[i] == key);
    end

    assign hit = |onehot;

    // Encode the one-hot match into a slot index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (onehot[i]) idx = idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/btb_repl.sv
// Round-robin replacement pointer: names the slot for the next allocation.
// Advances by one per allocation and wraps at ENTRIES-1.
module btb_repl #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Step the pointer on each allocation.
    always_ff @(posedge clk) begin
        if (!rst_n)           ptr <= '0;
        else if (advance)     ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

endmodule

// File: rtl/btb_store.sv
// Entry storage: valid bit, branch address, target and target instruction.
// One write and one invalidate per cycle. The caller never aims both at the
// same slot in one cycle; if it does, the write wins.
module btb_store #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int INSTR_W = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ADDR_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0]  wr_target,
    input  logic [INSTR_W-1:0] wr_instr,
    input  logic               inv_en,
    input  logic [IDX_W-1:0]   inv_idx,
    output logic [ENTRIES-1:0] valid,
    output logic [ADDR_W-1:0]  tags    [ENTRIES],
    output logic [ADDR_W-1:0]  targets [ENTRIES],
    output logic [INSTR_W-1:0] instrs  [ENTRIES]
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic sel_wr;
        logic sel_inv;
        assign sel_wr  = wr_en  && (wr_idx  == IDX_W'(i));
        assign sel_inv = inv_en && (inv_idx == IDX_W'(i));

        // Valid bit: set by a write, cleared by reset or invalidate.
        always_ff @(posedge clk) begin
            if (!rst_n)       valid[i] <= 1'b0;
            else if (sel_wr)  valid[i] <= 1'b1;
            else if (sel_inv) valid[i] <= 1'b0;
        end

        // Payload: loaded on a write, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tags[i]    <= '0;
                targets[i] <= '0;
                instrs[i]  <= '0;
            end else if (sel_wr) begin
                tags[i]    <= wr_tag;
                targets[i] <= wr_target;
                instrs[i]  <= wr_instr;
            end
        end
    end

endmodule

// File: rtl/btb_predictor.sv
// Fetch-stage branch target predictor, top level.
// The lookup is combinational on fetch_pc. Resolves from execute change the
// table at the next clock edge. A resolve for the address being fetched
// overrides the stored result in the same cycle.
// Assumes one resolve per cycle and that fetch consumes the outputs in the
// cycle they are produced.
module btb_predictor #(
    parameter int ENTRIES     = 16,
    parameter int ADDR_W      = 32,
    parameter int INSTR_W     = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  fetch_pc,
    output logic               pred_hit,
    output logic [ADDR_W-1:0]  pred_next_pc,
    output logic [INSTR_W-1:0] pred_instr,
    input  logic               upd_valid,
    input  logic [ADDR_W-1:0]  upd_pc,
    input  logic               upd_taken,
    input  logic [ADDR_W-1:0]  upd_target,
    input  logic [INSTR_W-1:0] upd_instr
);
    import btb_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    logic [ENTRIES-1:0] valid;
    logic [ADDR_W-1:0]  tags    [ENTRIES];
    logic [ADDR_W-1:0]  targets [ENTRIES];
    logic [INSTR_W-1:0] instrs  [ENTRIES];

    logic [ENTRIES-1:0] fetch_match;
    logic               fetch_hit;
    logic [IDX_W-1:0]   fetch_idx;
    logic [ENTRIES-1:0] upd_match;
    logic               upd_hit;
    logic [IDX_W-1:0]   upd_idx;
    logic [IDX_W-1:0]   alloc_ptr;
    logic               alloc_go;
    upd_kind_e          upd_kind;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    logic               bypass;
    logic [ADDR_W-1:0]  seq_pc;

    btb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_fetch_cam (
        .key(fetch_pc), .valid(valid), .tags(tags),
        .onehot(fetch_match), .hit(fetch_hit), .idx(fetch_idx)
    );

    btb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_upd_cam (
        .key(upd_pc), .valid(valid), .tags(tags),
        .onehot(upd_match), .hit(upd_hit), .idx(upd_idx)
    );

    btb_repl #(.ENTRIES(ENTRIES)) u_repl (
        .clk(clk), .rst_n(rst_n), .advance(alloc_go), .ptr(alloc_ptr)
    );

    // Decode the resolve into one table action.
    always_comb begin
        upd_kind = classify(upd_valid, upd_taken, upd_hit);
        alloc_go = (upd_kind == UPD_ALLOC);
        wr_en    = (upd_kind == UPD_ALLOC) || (upd_kind == UPD_REWRITE);
        wr_idx   = (upd_kind == UPD_ALLOC) ? alloc_ptr : upd_idx;
    end

    btb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(upd_pc),
        .wr_target(upd_target), .wr_instr(upd_instr),
        .inv_en(upd_kind == UPD_DROP), .inv_idx(upd_idx),
        .valid(valid), .tags(tags), .targets(targets), .instrs(instrs)
    );

    assign seq_pc = fetch_pc + STEP;
    assign bypass = upd_valid && (upd_pc == fetch_pc);

    // Select the prediction: same-cycle resolve, stored entry, or sequential.
    always_comb begin
        if (bypass) begin
            pred_hit     = upd_taken;
            pred_next_pc = upd_taken ? upd_target : seq_pc;
            pred_instr   = upd_taken ? upd_instr  : '0;
        end else if (fetch_hit) begin
            pred_hit     = 1'b1;
            pred_next_pc = targets[fetch_idx];
            pred_instr   = instrs[fetch_idx];
        end else begin
            pred_hit     = 1'b0;
            pred_next_pc = seq_pc;
            pred_instr   = '0;
        end
    end

endmodule

// File: rtl/btb_predictor_chk.sv
// Property checker for btb_predictor, bound into every instance.
// Observes ports plus the match vectors and the replacement pointer.
module btb_predictor_chk #(
    parameter int ENTRIES     = 16,
    parameter int ADDR_W      = 32,
    parameter int INSTR_W     = 32,
    parameter int INSTR_BYTES = 4,
    localparam int IDX_W      = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  fetch_pc,
    input logic               pred_hit,
    input logic [ADDR_W-1:0]  pred_next_pc,
    input logic [INSTR_W-1:0] pred_instr,
    input logic               upd_valid,
    input logic [ADDR_W-1:0]  upd_pc,
    input logic               upd_taken,
    input logic [ADDR_W-1:0]  upd_target,
    input logic [INSTR_W-1:0] upd_instr,
    input logic [ENTRIES-1:0] fetch_match,
    input logic [ENTRIES-1:0] upd_match,
    input logic [IDX_W-1:0]   alloc_ptr,
    input logic               alloc_go
);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && !upd_valid) |-> (!pred_hit && alloc_ptr == '0));

    // R2
    miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (pred_next_pc == fetch_pc + ADDR_W'(INSTR_BYTES) && pred_instr == '0));

    // R3
    taken_learn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=>
        (upd_valid || fetch_pc != $past(upd_pc) ||
         (pred_hit && pred_next_pc == $past(upd_target) && pred_instr == $past(upd_instr))));

    // R5
    drop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) |=>
        (upd_valid || fetch_pc != $past(upd_pc) || !pred_hit));

    // R6
    rewrite_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && (|upd_match)) |=> $stable(alloc_ptr));

    // R7
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_go |=> (alloc_ptr == (($past(alloc_ptr) == IDX_W'(ENTRIES - 1)) ?
                                    '0 : $past(alloc_ptr) + 1'b1)));

    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_go |=> $stable(alloc_ptr));

    // R8
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_pc == fetch_pc) |->
        (pred_hit == upd_taken && (!upd_taken ||
         (pred_next_pc == upd_target && pred_instr == upd_instr))));

    // R9
    unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fetch_match) && $onehot0(upd_match));

endmodule

bind btb_predictor btb_predictor_chk #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .INSTR_BYTES(INSTR_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_next_pc(pred_next_pc), .pred_instr(pred_instr),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_instr(upd_instr),
    .fetch_match(fetch_match), .upd_match(upd_match),
    .alloc_ptr(alloc_ptr), .alloc_go(alloc_go)
);

// File: tb/btb_predictor_tb.sv
// Bench for btb_predictor: a behavioural model checked on every cycle.
module btb_predictor_tb;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit;
    logic [31:0] pred_next_pc;
    logic [31:0] pred_instr;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic [31:0] upd_instr = '0;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // Model: slots in allocation order, plus the next slot to fill.
    bit          m_v  [N];
    logic [31:0] m_pc [N];
    logic [31:0] m_tg [N];
    logic [31:0] m_in [N];
    int          m_ptr = 0;

    always #5 clk = ~clk;

    btb_predictor u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_hit(pred_hit), .pred_next_pc(pred_next_pc), .pred_instr(pred_instr),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_instr(upd_instr)
    );

    function automatic int find(logic [31:0] pc);
        for (int i = 0; i < N; i++) if (m_v[i] && m_pc[i] == pc) return i;
        return -1;
    endfunction

    // One cycle: drive, compare mid-cycle, then advance the model at the edge.
    task automatic cycle(input logic [31:0] f, input bit uv, input logic [31:0] up,
                         input bit ut, input logic [31:0] tg, input logic [31:0] ins,
                         input string req);
        bit e_hit; logic [31:0] e_pc; logic [31:0] e_in; int k; string r;
        @(negedge clk);
        fetch_pc = f; upd_valid = uv; upd_pc = up; upd_taken = ut;
        upd_target = tg; upd_instr = ins;
        #1;
        k = find(f);
        if (uv && up == f) begin
            e_hit = ut; e_pc = ut ? tg : f + 4; e_in = ut ? ins : '0; r = "R8";
        end else if (k >= 0) begin
            e_hit = 1; e_pc = m_tg[k]; e_in = m_in[k]; r = "R3";
        end else begin
            e_hit = 0; e_pc = f + 4; e_in = '0; r = "R2";
        end
        if (req != "") r = req;
        vectors++;
        if (pred_hit !== e_hit || pred_next_pc !== e_pc || pred_instr !== e_in) begin
            misses++;
            $display("FAIL %s pc=%h got hit=%b next=%h instr=%h exp hit=%b next=%h instr=%h",
                     r, f, pred_hit, pred_next_pc, pred_instr, e_hit, e_pc, e_in);
        end
        @(posedge clk);
        if (uv) begin
            k = find(up);
            if (ut && k >= 0) begin
                m_tg[k] = tg; m_in[k] = ins;
            end else if (ut) begin
                m_v[m_ptr] = 1; m_pc[m_ptr] = up; m_tg[m_ptr] = tg; m_in[m_ptr] = ins;
                m_ptr = (m_ptr + 1) % N;
            end else if (k >= 0) begin
                m_v[k] = 0;
            end
        end
    endtask

    task automatic look(input logic [31:0] f, input string req);
        cycle(f, 0, '0, 0, '0, '0, req);
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: empty table after reset
        look(32'h100, "R1"); look(32'h0, "R1"); look(32'hFFFF_FFFC, "R1");
        // R3 learn, then look up; R8 bypass taken and not taken
        cycle(32'h100, 1, 32'h100, 1, 32'h200, 32'hAAAA_0001, "R8");
        look(32'h100, "R3");
        look(32'h104, "R2");
        // R4: not-taken resolve of unknown PC leaves it absent
        cycle(32'h0, 1, 32'h300, 0, 32'h900, 32'h1, "R4");
        look(32'h300, "R4");
        // R6: retarget in place
        cycle(32'h0, 1, 32'h100, 1, 32'h400, 32'hBBBB_0002, "R6");
        look(32'h100, "R6");
        // R8: not-taken resolve overrides a stored hit in the same cycle
        cycle(32'h100, 1, 32'h100, 0, 32'h0, 32'h0, "R8");
        // R5 and R9: entry gone, no stale copy left behind
        look(32'h100, "R5");
        look(32'h100, "R9");
        // R7: 17 allocations wrap the table
        for (int i = 0; i <= N; i++)
            cycle(32'h0, 1, 32'h2000 + 4 * i, 1, 32'h5000 + i, 32'hC000 + i, "R7");
        look(32'h2000, "R7");
        look(32'h2004, "R7");
        look(32'h2000 + 4 * N, "R7");
        // Mixed random stream over a small address set
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, b;
            a = 32'h1000 + 4 * ($urandom % 24);
            b = ($urandom % 4 == 0) ? a : 32'h1000 + 4 * ($urandom % 24);
            cycle(a, ($urandom % 3) != 0, b, ($urandom % 4) != 0,
                  32'h8000 + ($urandom % 64) * 4, $urandom, "");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog got hung run exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule